// File: doc/BRIEF.md
# Double-Buffered Byte-Loaded Converter Input Register

This block is the digital front end of a 10-bit digital-to-analog converter. A processor loads a 10-bit code into a first-stage input latch, either in one full-width write or as two byte writes. The code moves into a second-stage converter register only when a separate transfer command is given. Software can therefore prepare the next code while the converter keeps producing the current one, and the output never shows a half-written code.

The input latch has two sections: an upper section of 8 bits and a lower section of 2 bits. A byte-sequence select chooses which sections a write updates. When the select is high, a write fills both sections. When it is low, a write fills only the lower section from the two least significant data inputs, and only then can a transfer happen. The level-sensitive strobes are modelled on a system clock: each enable is sampled on every rising edge. A transfer in the same cycle as a lower-section write forwards the freshly written bits, which mimics a transparent latch.

Top module: `dac_dbuf_front`

## Requirements
- R1: An active-low synchronous reset clears both the input latch and the converter register to zero, so `code_out` reads 0x000 after reset.
- R2: A write takes effect only while `cs_n` and `wr_n` are both low. With `cs_n` high the input latch keeps its contents, and a later transfer shows the old contents.
- R3: A valid write with `seq_full` high loads all 10 bits of the input latch from `din`. `din[9]` is the MSB and `din[0]` is the LSB. The write does not change `code_out`.
- R4: A valid write with `seq_full` low loads only the lower 2-bit section from `din[1:0]`. The upper 8 bits are left unchanged.
- R5: When `xfer_n`, `wr_n` and `seq_full` are all low on a clock edge, `code_out` takes the value {upper section, lower section} on that edge. If a lower-section write happens on the same edge, the new `din[1:0]` bits are included.
- R6: While `seq_full` is high, no transfer takes place and `code_out` holds.
- R7: While `xfer_n` is high, `code_out` holds, even during writes.
- R8: With `wr_n` high, `xfer_n` low has no effect on `code_out`.
- R9: A transfer does not need `cs_n`. With `cs_n` high, it forwards the held latch contents, and bit i of the latch drives bit i of `code_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low, enables the write strobe |
| wr_n | input | 1 | Write strobe, active low |
| seq_full | input | 1 | Byte-sequence select: high = load all bits, low = load low section and allow transfer |
| xfer_n | input | 1 | Transfer strobe, active low |
| din | input | 10 | Data inputs, bit 9 MSB |
| code_out | output | 10 | Code held in the converter register |

## Verification
The bench builds the block with its default widths: a 10-bit code whose lower section is 2 bits wide. With these defaults the high/low split can be checked directly. Codes such as 0x3FF followed by a lower-section write of 00 show that the upper 8 bits survive a byte write, and 0x001 versus 0x200 exposes any swap of the MSB and LSB. The vectors interleave full writes, byte writes and transfers with each strobe withheld in turn. This covers the combinations that separate a held value from a forwarded one.

// File: rtl/dac_dbuf_pkg.sv
// Shared types for the double-buffered converter input register.
// Assumes all strobes have already been decoded into active-high enables.
package dac_dbuf_pkg;
    typedef struct packed {
        logic load_hi;   // update upper section of the input latch
        logic load_lo;   // update lower section of the input latch
        logic xfer;      // copy input latch into converter register
    } dbuf_en_t;
endpackage

// File: rtl/dbuf_ctrl.sv
// Strobe decoder: turns the active-low level strobes into per-stage enables.
// Assumes inputs are already synchronous to clk.
module dbuf_ctrl
    import dac_dbuf_pkg::*;
(
    input  logic     cs_n,
    input  logic     wr_n,
    input  logic     seq_full,
    input  logic     xfer_n,
    output dbuf_en_t en
);
    logic wr_valid;

    // Decode chip select, write, byte sequence and transfer into enables.
    always_comb begin
        wr_valid   = !cs_n && !wr_n;
        en.load_hi = wr_valid && seq_full;
        en.load_lo = wr_valid;
        en.xfer    = !xfer_n && !wr_n && !seq_full;
    end
endmodule

// File: rtl/dbuf_in_latch.sv
// First-stage input latch, split into an upper and a lower section.
// The lower section always loads from din[LO_W-1:0] and the upper one from
// the remaining bits. lo_next exposes this cycle's lower value for flow-through.
module dbuf_in_latch
    import dac_dbuf_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int LO_W   = 2,
    localparam int HI_W  = CODE_W - LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dbuf_en_t          en,
    input  logic [CODE_W-1:0] din,
    output logic [HI_W-1:0]   hi_q,
    output logic [LO_W-1:0]   lo_q,
    output logic [LO_W-1:0]   lo_next
);
    // Upper section: loaded only by full-width writes.
    always_ff @(posedge clk) begin
        if (!rst_n)          hi_q <= '0;
        else if (en.load_hi) hi_q <= din[CODE_W-1:LO_W];
    end

    // Lower section: loaded by every valid write.
    always_ff @(posedge clk) begin
        if (!rst_n)          lo_q <= '0;
        else if (en.load_lo) lo_q <= din[LO_W-1:0];
    end

    // Value the lower section holds after this edge, for same-cycle transfer.
    always_comb lo_next = en.load_lo ? din[LO_W-1:0] : lo_q;
endmodule

// File: rtl/dbuf_dac_reg.sv
// Second-stage converter register: copies the assembled latch word on transfer.
// Assumes the upper section cannot change on a transfer edge.
module dbuf_dac_reg
    import dac_dbuf_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int LO_W   = 2,
    localparam int HI_W  = CODE_W - LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dbuf_en_t          en,
    input  logic [HI_W-1:0]   hi_q,
    input  logic [LO_W-1:0]   lo_next,
    output logic [CODE_W-1:0] code_q
);
    // Hold the converter code; load it on a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)       code_q <= '0;
        else if (en.xfer) code_q <= {hi_q, lo_next};
    end
endmodule

// File: rtl/dac_dbuf_front.sv
// Top level of the double-buffered converter input register.
// Assumes all strobes are synchronous to clk and the reset is synchronous.
module dac_dbuf_front
    import dac_dbuf_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int LO_W   = 2,
    localparam int HI_W  = CODE_W - LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              seq_full,
    input  logic              xfer_n,
    input  logic [CODE_W-1:0] din,
    output logic [CODE_W-1:0] code_out
);
    dbuf_en_t        en;
    logic [HI_W-1:0] lat_hi;
    logic [LO_W-1:0] lat_lo;
    logic [LO_W-1:0] lat_lo_next;

    dbuf_ctrl u_ctrl (
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .seq_full (seq_full),
        .xfer_n   (xfer_n),
        .en       (en)
    );

    dbuf_in_latch #(.CODE_W(CODE_W), .LO_W(LO_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .din     (din),
        .hi_q    (lat_hi),
        .lo_q    (lat_lo),
        .lo_next (lat_lo_next)
    );

    dbuf_dac_reg #(.CODE_W(CODE_W), .LO_W(LO_W)) u_dac (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .hi_q    (lat_hi),
        .lo_next (lat_lo_next),
        .code_q  (code_out)
    );
endmodule

// File: rtl/dac_dbuf_chk.sv
// Property checker for dac_dbuf_front, attached with bind below.
module dac_dbuf_chk #(
    parameter int CODE_W = 10,
    parameter int LO_W   = 2,
    localparam int HI_W  = CODE_W - LO_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              wr_n,
    input logic              seq_full,
    input logic              xfer_n,
    input logic [CODE_W-1:0] din,
    input logic [CODE_W-1:0] code_out,
    input logic [HI_W-1:0]   lat_hi,
    input logic [LO_W-1:0]   lat_lo
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (code_out == '0 && lat_hi == '0 && lat_lo == '0));

    assert_cs_gates_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(lat_hi) && $stable(lat_lo)));

    assert_full_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && seq_full) |=> ({lat_hi, lat_lo} == $past(din)));

    assert_byte_keeps_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && !seq_full) |=> ($stable(lat_hi) && lat_lo == $past(din[LO_W-1:0])));

    assert_xfer_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_n && !wr_n && !seq_full && !cs_n) |=> (code_out == {$past(lat_hi), $past(din[LO_W-1:0])}));

    assert_no_xfer_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_full |=> $stable(code_out));

    assert_no_xfer_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_n |=> $stable(code_out));

    assert_no_xfer_nowr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_n |=> $stable(code_out));

    assert_xfer_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_n && !wr_n && !seq_full && cs_n) |=> (code_out == {$past(lat_hi), $past(lat_lo)}));
endmodule

bind dac_dbuf_front dac_dbuf_chk #(.CODE_W(CODE_W), .LO_W(LO_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .wr_n     (wr_n),
    .seq_full (seq_full),
    .xfer_n   (xfer_n),
    .din      (din),
    .code_out (code_out),
    .lat_hi   (lat_hi),
    .lat_lo   (lat_lo)
);

// File: tb/test_dac_dbuf_front.sv
// Self-checking bench: a vector table, then directed reset checks.
module test_dac_dbuf_front;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       seq_full = 1'b0;
    logic       xfer_n = 1'b1;
    logic [9:0] din = '0;
    logic [9:0] code_out;
    int         total = 0;
    int         bad = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    dac_dbuf_front i_dac_dbuf_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
        .seq_full(seq_full), .xfer_n(xfer_n), .din(din), .code_out(code_out)
    );

    // Entry: [23] cs_n [22] wr_n [21] seq_full [20] xfer_n [19:10] din [9:0] expected code
    localparam int NV = 13;
    localparam logic [23:0] VEC [0:NV-1] = '{
        {4'b0011, 10'h2AB, 10'h000},  // R3 full write, R7 no transfer
        {4'b1100, 10'h000, 10'h000},  // R8 xfer without write
        {4'b0000, 10'h001, 10'h2A9},  // R4 R5 byte write with flow-through transfer
        {4'b0010, 10'h3FF, 10'h2A9},  // R6 xfer blocked while seq_full high
        {4'b1000, 10'h002, 10'h3FF},  // R9 R2 transfer held latch, cs_n high
        {4'b1011, 10'h155, 10'h3FF},  // R2 write ignored with cs_n high
        {4'b0000, 10'h000, 10'h3FC},  // R2 R4 upper kept from 0x3FF
        {4'b0011, 10'h200, 10'h3FC},  // R3 full write MSB only
        {4'b0001, 10'h003, 10'h3FC},  // R7 byte write, no transfer
        {4'b1100, 10'h000, 10'h3FC},  // R8
        {4'b1000, 10'h000, 10'h203},  // R9 R4 held word forwarded
        {4'b0011, 10'h001, 10'h203},  // R3 LSB only
        {4'b1000, 10'h000, 10'h001}   // R9 bit order
    };

    task automatic check(input string req, input logic [9:0] exp);
        total++;
        if (code_out !== exp) begin
            bad++;
            $display("FAIL %s code_out=%h expected=%h", req, code_out, exp);
        end
    endtask

    task automatic idle();
        cs_n = 1'b1; wr_n = 1'b1; seq_full = 1'b0; xfer_n = 1'b1; din = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 10'h000);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            {cs_n, wr_n, seq_full, xfer_n} = VEC[i][23:20];
            din = VEC[i][19:10];
            @(negedge clk);
            check($sformatf("vector %0d R2-group", i), VEC[i][9:0]);
        end
        idle();
        @(negedge clk);
        check("R7", 10'h001);
        // R1: reset mid-run clears the converter register
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 10'h000);
        rst_n = 1'b1;
        // R1: latch also cleared, so a held transfer yields zero
        cs_n = 1'b1; wr_n = 1'b0; seq_full = 1'b0; xfer_n = 1'b0;
        @(negedge clk);
        check("R1", 10'h000);
        // R3 then R5: full load, then byte write with transfer
        cs_n = 1'b0; wr_n = 1'b0; seq_full = 1'b1; xfer_n = 1'b1; din = 10'h1C2;
        @(negedge clk);
        check("R3", 10'h000);
        seq_full = 1'b0; xfer_n = 1'b0; din = 10'h003;
        @(negedge clk);
        check("R5", 10'h1C3);
        idle();
        @(negedge clk);
        check("R8", 10'h1C3);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule